// File: doc/BRIEF.md
# Switch Power-Up Reset and Default Setup Sequencer

This block brings an external Ethernet switch out of reset and into a known default setup. A single start pulse launches the sequence. The block drives the switch's reset line high, then low, then high again, with each level held for a programmable number of milliseconds. While reset is low it drives strap levels onto the serial clock and data pins, so the switch samples them when reset rises. After the last hold it releases the serial pins and leaves reset driven high.

It then hands a fixed burst of configuration writes to a serial register master through a one-cycle request and done handshake. There are six per-port setup writes and one VLAN mode write. When the last write completes, the block raises a done flag, and the flag stays high until the next start.

Delays are counted in millisecond ticks taken from a system-clock divider. The divider ratio is a parameter, so a bench can shrink the whole waveform to a few hundred cycles.

Top module: `swrst_seq`

## Requirements
- R1: Out of reset, every output enable (reset, clock, data, select) is low, `wr_req` is low and `done` is low.
- R2: After `start`, the reset line is driven high for exactly `T_PRE_MS*CLKS_PER_MS` cycles (default 20 ms), with the serial pins not driven.
- R3: The reset line is then driven low for exactly `T_LOW_MS*CLKS_PER_MS` cycles (default 100 ms).
- R4: During the low phase and the following high phase, the clock pin is driven to 1, the data pin is driven to 0, and the select pin is not driven.
- R5: Reset is then driven high again, with the straps still applied, for exactly `T_POST_MS*CLKS_PER_MS` cycles (default 30 ms).
- R6: After that high phase, the clock, data and select enables drop to 0, and the reset line stays driven high from then on until the next start or reset.
- R7: Exactly seven writes follow, in this address order: 0x01, 0x03, 0x05, 0x07, 0x08, 0x09, 0x11.
- R8: The first five port writes carry 0x800F. This value sets bit 15 for crossover auto-detect and bits 3:0 for flow control, auto-negotiation, 100 Mb/s and full duplex. The sixth write is to the CPU port, index 5, and carries 0x801F, which adds bit 4 for tagging. The write to 0x11 carries 0xFF30.
- R9: Each write is one single-cycle `wr_req`. Address and data stay stable until `wr_done`. No new request is issued before the `wr_done` of the previous one.
- R10: `done` rises in the cycle after the last `wr_done` and stays high, with no further request, until the next `start`.
- R11: A `start` that arrives while the sequence is running has no effect on phase lengths or on the write list.
- R12: A `start` while `done` is high clears `done` and replays the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches the sequence |
| rc_o | output | 1 | Switch reset line level |
| rc_oe | output | 1 | Switch reset line output enable |
| sk_o | output | 1 | Serial clock pin level (strap) |
| sk_oe | output | 1 | Serial clock pin output enable |
| di_o | output | 1 | Serial data pin level (strap) |
| di_oe | output | 1 | Serial data pin output enable |
| cs_o | output | 1 | Serial select pin level |
| cs_oe | output | 1 | Serial select pin output enable |
| wr_req | output | 1 | One-cycle register write request to the serial master |
| wr_addr | output | 8 | Register address of the current write |
| wr_data | output | 16 | Register value of the current write |
| wr_done | input | 1 | One-cycle completion from the serial master |
| done | output | 1 | Whole sequence complete |

## Verification
The handshake assertions assume the serial master pulses `wr_done` for one cycle, and only after it has seen a request, never in the same cycle as `wr_req`. The bench's responder model waits at least one cycle after each request before it answers, and the answer latency varies per write across a vector table. `start` is assumed to be a one-cycle pulse. The bench drives it that way at idle, inside the low phase, during the write burst and after `done`.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int NPORTS   = 6;
  localparam int CPU_PORT = 5;
  localparam int NWR      = NPORTS + 1;
  localparam int IDX_W    = $clog2(NWR);

  localparam logic [DATA_W-1:0] PORT_BASE = 16'h800F;
  localparam logic [DATA_W-1:0] TAG_BIT   = 16'h0010;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 8'h11;
  localparam logic [DATA_W-1:0] MODE_VAL  = 16'hFF30;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_LOW,
    PH_POST,
    PH_ISSUE,
    PH_WAIT,
    PH_DONE
  } phase_e;

  // Port setup registers: odd addresses for the first four ports, contiguous after.
  function automatic logic [ADDR_W-1:0] port_addr(input int unsigned i);
    return (i < 4) ? ADDR_W'(2 * i + 1) : ADDR_W'(i + 4);
  endfunction

  function automatic logic [DATA_W-1:0] port_val(input int unsigned i);
    return (i == CPU_PORT) ? (PORT_BASE | TAG_BIT) : PORT_BASE;
  endfunction

endpackage

// File: rtl/swrst_timer.sv
module swrst_timer #(
  parameter int CLKS_PER_MS = 1000,
  parameter int MS_W        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [MS_W-1:0] limit_ms,
  output logic            tick,
  output logic            expire
);
  localparam int DIV_W = $clog2(CLKS_PER_MS + 1);

  logic [DIV_W-1:0] div_q;
  logic [MS_W-1:0]  ms_q;

  assign tick   = (div_q == DIV_W'(CLKS_PER_MS - 1));
  assign expire = tick && (ms_q == limit_ms - MS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ms_q  <= '0;
    end else if (clr) begin
      div_q <= '0;
      ms_q  <= '0;
    end else if (tick) begin
      div_q <= '0;
      ms_q  <= ms_q + MS_W'(1);
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/swrst_wlist.sv
module swrst_wlist
  import swrst_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              last
);
  always_comb begin
    if (int'(idx) < NPORTS) begin
      addr = port_addr(int'(idx));
      data = port_val(int'(idx));
    end else begin
      addr = MODE_ADDR;
      data = MODE_VAL;
    end
    last = (int'(idx) == NWR - 1);
  end
endmodule

// File: rtl/swrst_fsm.sv
module swrst_fsm
  import swrst_pkg::*;
#(
  parameter int T_PRE_MS  = 20,
  parameter int T_LOW_MS  = 100,
  parameter int T_POST_MS = 30,
  parameter int MS_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             expire,
  input  logic             wr_done,
  input  logic             last,
  output logic             tmr_clr,
  output logic [MS_W-1:0]  limit_ms,
  output logic [IDX_W-1:0] idx,
  output phase_e           phase
);
  phase_e nxt;
  logic   timed;

  assign timed   = (phase == PH_PRE) || (phase == PH_LOW) || (phase == PH_POST);
  assign tmr_clr = !timed || expire;

  always_comb begin
    case (phase)
      PH_PRE:  limit_ms = MS_W'(T_PRE_MS);
      PH_LOW:  limit_ms = MS_W'(T_LOW_MS);
      default: limit_ms = MS_W'(T_POST_MS);
    endcase
  end

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE:  if (start) nxt = PH_PRE;
      PH_PRE:   if (expire) nxt = PH_LOW;
      PH_LOW:   if (expire) nxt = PH_POST;
      PH_POST:  if (expire) nxt = PH_ISSUE;
      PH_ISSUE: nxt = PH_WAIT;
      PH_WAIT:  if (wr_done) nxt = last ? PH_DONE : PH_ISSUE;
      PH_DONE:  if (start) nxt = PH_PRE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      phase <= nxt;
      if (nxt == PH_PRE)
        idx <= '0;
      else if (phase == PH_WAIT && wr_done && !last)
        idx <= idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/swrst_seq.sv
module swrst_seq
  import swrst_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int T_PRE_MS    = 20,
  parameter int T_LOW_MS    = 100,
  parameter int T_POST_MS   = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rc_o,
  output logic              rc_oe,
  output logic              sk_o,
  output logic              sk_oe,
  output logic              di_o,
  output logic              di_oe,
  output logic              cs_o,
  output logic              cs_oe,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_done,
  output logic              done
);
  localparam int MAX_MS = (T_LOW_MS > T_PRE_MS) ?
                          ((T_LOW_MS > T_POST_MS) ? T_LOW_MS : T_POST_MS) :
                          ((T_PRE_MS > T_POST_MS) ? T_PRE_MS : T_POST_MS);
  localparam int MS_W = $clog2(MAX_MS + 1);

  phase_e           phase;
  logic             tmr_clr;
  logic             ms_tick;
  logic             phase_expire;
  logic [MS_W-1:0]  limit_ms;
  logic [IDX_W-1:0] idx;
  logic             list_last;
  logic             strap_on;
  logic             busy;

  swrst_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_W(MS_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .limit_ms (limit_ms),
    .tick     (ms_tick),
    .expire   (phase_expire)
  );

  swrst_fsm #(
    .T_PRE_MS (T_PRE_MS),
    .T_LOW_MS (T_LOW_MS),
    .T_POST_MS(T_POST_MS),
    .MS_W     (MS_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .expire   (phase_expire),
    .wr_done  (wr_done),
    .last     (list_last),
    .tmr_clr  (tmr_clr),
    .limit_ms (limit_ms),
    .idx      (idx),
    .phase    (phase)
  );

  swrst_wlist u_wlist (
    .idx  (idx),
    .addr (wr_addr),
    .data (wr_data),
    .last (list_last)
  );

  assign strap_on = (phase == PH_LOW) || (phase == PH_POST);
  assign busy     = (phase != PH_IDLE) && (phase != PH_DONE);

  assign rc_oe  = (phase != PH_IDLE);
  assign rc_o   = (phase != PH_IDLE) && (phase != PH_LOW);
  assign sk_oe  = strap_on;
  assign sk_o   = strap_on;
  assign di_oe  = strap_on;
  assign di_o   = 1'b0;
  assign cs_oe  = 1'b0;
  assign cs_o   = 1'b0;
  assign wr_req = (phase == PH_ISSUE);
  assign done   = (phase == PH_DONE);
endmodule

// File: rtl/swrst_seq_chk.sv
module swrst_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        rc_o,
  input logic        rc_oe,
  input logic        sk_o,
  input logic        sk_oe,
  input logic        di_o,
  input logic        di_oe,
  input logic        cs_oe,
  input logic        wr_req,
  input logic [7:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        wr_done,
  input logic        done,
  input logic        busy
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (wr_req)  pend <= 1'b1;
    else if (wr_done) pend <= 1'b0;
  end

  AST_STRAP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    sk_oe |-> (sk_o && di_oe && !di_o && !cs_oe)); // R4
  AST_STRAP_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sk_oe |-> rc_oe); // R4
  AST_REQ_PINS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (rc_oe && rc_o && !sk_oe && !di_oe && !cs_oe)); // R6
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req); // R9
  AST_NO_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !wr_req); // R9
  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> ($stable(wr_addr) && $stable(wr_data))); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_req && !busy && rc_oe && rc_o)); // R10
  AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(wr_done && pend)) |=> $stable(rc_o)); // R11
endmodule

bind swrst_seq swrst_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .rc_o    (rc_o),
  .rc_oe   (rc_oe),
  .sk_o    (sk_o),
  .sk_oe   (sk_oe),
  .di_o    (di_o),
  .di_oe   (di_oe),
  .cs_oe   (cs_oe),
  .wr_req  (wr_req),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .wr_done (wr_done),
  .done    (done),
  .busy    (busy)
);

// File: tb/swrst_seq_test.sv
`timescale 1ns/1ps
module swrst_seq_test;
  localparam int CPM  = 4;
  localparam int PRE  = 20;
  localparam int LOW  = 100;
  localparam int POST = 30;
  localparam int NV   = 7;

  // {latency, addr, data}
  localparam logic [31:0] VEC [NV] = '{
    {8'd0, 8'h01, 16'h800F},
    {8'd3, 8'h03, 16'h800F},
    {8'd1, 8'h05, 16'h800F},
    {8'd5, 8'h07, 16'h800F},
    {8'd0, 8'h08, 16'h800F},
    {8'd2, 8'h09, 16'h801F},
    {8'd7, 8'h11, 16'hFF30}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wr_done = 1'b0;
  logic rc_o, rc_oe, sk_o, sk_oe, di_o, di_oe, cs_o, cs_oe, wr_req, done;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  swrst_seq #(.CLKS_PER_MS(CPM), .T_PRE_MS(PRE), .T_LOW_MS(LOW), .T_POST_MS(POST)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rc_o(rc_o), .rc_oe(rc_oe), .sk_o(sk_o), .sk_oe(sk_oe),
    .di_o(di_o), .di_oe(di_oe), .cs_o(cs_o), .cs_oe(cs_oe),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Runs one full sequence; optionally pulses start inside the low phase and the write burst.
  task automatic run_seq(input bit inject);
    int cnt;
    int bad;
    int guard;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done, "R12 done cleared by start", done, 0);
    cnt = 0;
    while (rc_oe && rc_o && !sk_oe && cnt < 10000) begin cnt++; @(negedge clk); end
    check(cnt == PRE * CPM, "R2 high hold cycles", cnt, PRE * CPM);
    cnt = 0; bad = 0;
    while (rc_oe && !rc_o && cnt < 10000) begin
      if (!(sk_oe && sk_o && di_oe && !di_o && !cs_oe)) bad++;
      cnt++;
      if (inject && cnt == 10) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    check(cnt == LOW * CPM, "R3 low hold cycles (R11 if injected)", cnt, LOW * CPM);
    check(bad == 0, "R4 straps during low", bad, 0);
    cnt = 0; bad = 0;
    while (rc_oe && rc_o && sk_oe && cnt < 10000) begin
      if (!(sk_o && di_oe && !di_o && !cs_oe)) bad++;
      cnt++; @(negedge clk);
    end
    check(cnt == POST * CPM, "R5 post hold cycles", cnt, POST * CPM);
    check(bad == 0, "R4 straps during post", bad, 0);
    check(rc_oe && rc_o && !sk_oe && !di_oe && !cs_oe, "R6 pins released",
          {rc_oe, rc_o, sk_oe, di_oe, cs_oe}, 5'b11000);
    for (int k = 0; k < NV; k++) begin
      guard = 0;
      while (!wr_req && guard < 100) begin guard++; @(negedge clk); end
      check(wr_req, "R7 request present", wr_req, 1);
      check(wr_addr == VEC[k][23:16], "R7 write address", wr_addr, VEC[k][23:16]);
      check(wr_data == VEC[k][15:0], "R8 write data", wr_data, VEC[k][15:0]);
      check(!done, "R10 done low during burst", done, 0);
      bad = 0;
      for (int w = 0; w <= int'(VEC[k][31:24]); w++) begin
        @(negedge clk);
        if (wr_req) bad++;
      end
      check(bad == 0, "R9 no request while pending", bad, 0);
      wr_done = 1'b1;
      if (inject && k == 3) start = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
      start = 1'b0;
    end
    check(done, "R10 done after last write", done, 1);
    bad = 0;
    for (int w = 0; w < 40; w++) begin
      if (wr_req || !done || !rc_oe || !rc_o) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R10 done holds, no extra writes (R6 reset stays high)", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rc_oe && !sk_oe && !di_oe && !cs_oe && !wr_req && !done, "R1 reset state",
          {rc_oe, sk_oe, di_oe, cs_oe, wr_req, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!rc_oe && !done, "R1 idle after reset", {rc_oe, done}, 0);

    run_seq(1'b0);
    run_seq(1'b1);

    // Reset in the middle of the low phase returns everything to idle.
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (PRE * CPM + 50) @(negedge clk);
    check(rc_oe && !rc_o, "R3 in low phase", {rc_oe, rc_o}, 2'b10);
    rst_n = 1'b0;
    @(negedge clk);
    check(!rc_oe && !sk_oe && !di_oe && !wr_req && !done, "R1 mid-run reset",
          {rc_oe, sk_oe, di_oe, wr_req, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_seq(1'b0);

    finished = 1;
    report();
    $finish;
  end
endmodule